// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Condition Flags

This block is the purely combinational arithmetic and logic unit of a small eight-bit processor core. It takes a destination operand, a source operand and the stored carry flag, and an operation code. It returns the result byte, six condition flags and a per-flag update mask. The core owns the status register. It writes back only the flag bits whose mask bit is set. It writes the result byte only when the write strobe is high.

Subtraction has no separate datapath. The adder is reused with the source operand inverted and with the carry-in chosen per operation. The carry and half-carry produced by the adder are then inverted, so that after a subtract they mean "borrow". Compare operations run the full subtract and set flags, but they do not request a result write. Immediate forms need no extra logic: the core places the constant on the source operand input and selects the matching register-register operation code.

There is no clock, no state and no handshake. Every output is a function of the current inputs only.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 (add) gives result = (a + b) mod 256; the carry-in input is ignored.
- R2: Operation code 1 (add with carry) gives result = (a + b + carry_in) mod 256.
- R3: Operation codes 2 (subtract) and 4 (compare) give result = (a - b) mod 256.
- R4: Operation codes 3 (subtract with carry) and 5 (compare with carry) give result = (a - b - carry_in) mod 256.
- R5: Compare codes 4 and 5 hold res_wr low. All other defined codes (0 to 3 and 6 to 8) hold it high.
- R6: For an add, flag bit 0 (C) is the carry out of bit 7, and flag bit 5 (H) is the carry out of bit 3. For a subtract or compare, C is set when the unsigned subtrahend plus borrow exceeds the minuend, and H is set when the same is true of the low nibbles.
- R7: Flag bit 3 (V) is set for an arithmetic code exactly when the signed two's-complement result falls outside -128..127.
- R8: Flag bit 2 (N) equals result bit 7. Flag bit 1 (Z) is set exactly when the result is zero. Flag bit 4 (S) equals N XOR V.
- R9: Codes 6 (AND), 7 (OR) and 8 (XOR) give the bitwise result and clear V.
- R10: The update mask uses the same bit positions as the flags. It is 6'b111111 for codes 0 to 5 and 6'b011110 for codes 6 to 8, so C and H are left untouched by logic operations.
- R11: Codes 9 to 15 are unused. They give mask 0 and hold res_wr low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (see requirements) |
| opd_a | input | 8 | Destination operand (minuend / first addend) |
| opd_b | input | 8 | Source operand or immediate constant |
| carry_in | input | 1 | Stored C flag from the status register |
| res | output | 8 | Result byte |
| res_wr | output | 1 | Result should be written to the destination |
| flag_val | output | 6 | Flags {H,S,V,N,Z,C}, C at bit 0 |
| flag_upd | output | 6 | Per-flag write mask, same bit order |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench applies one operation and waits a short settle delay with no clock edge involved. It then samples result, write strobe, flags and mask together and compares them with values it computes from integer arithmetic. Each new stimulus is applied only after the previous sample, so no check can see a mix of two operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int NFLAG = 6;
  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_CMPC = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8
  } alu_op_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2
  } bw_sel_e;

  // carry out of one bit column, from its operand bits and sum bit
  function automatic logic col_carry(input logic d, input logic r, input logic x);
    return (d & r) | (r & ~x) | (d & ~x);
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);
  import alu8_pkg::*;
  localparam int MSB = W - 1;
  localparam int HB  = W / 2 - 1;

  logic [W-1:0] b_eff;
  logic         c_raw;
  logic         h_raw;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(W-1){1'b0}}, cin};
    c_raw = col_carry(a[MSB], b_eff[MSB], sum[MSB]);
    h_raw = col_carry(a[HB], b_eff[HB], sum[HB]);
    c_out = c_raw ^ sub;
    h_out = h_raw ^ sub;
    v_out = (a[MSB] & b_eff[MSB] & ~sum[MSB]) | (~a[MSB] & ~b_eff[MSB] & sum[MSB]);
  end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  alu8_pkg::bw_sel_e sel,
  output logic [W-1:0]      y
);
  import alu8_pkg::*;
  always_comb begin
    unique case (sel)
      BW_AND:  y = a & b;
      BW_OR:   y = a | b;
      BW_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flagpack.sv
module alu8_flagpack #(
  parameter int W = 8
) (
  input  logic [W-1:0]               res,
  input  logic                       is_arith,
  input  logic                       is_logic,
  input  logic                       c_in,
  input  logic                       h_in,
  input  logic                       v_in,
  output logic [alu8_pkg::NFLAG-1:0] fval,
  output logic [alu8_pkg::NFLAG-1:0] fupd
);
  import alu8_pkg::*;
  logic n_b;
  logic v_b;

  always_comb begin
    n_b = res[W-1];
    v_b = is_arith ? v_in : 1'b0;
    fval      = '0;
    fval[F_C] = is_arith & c_in;
    fval[F_H] = is_arith & h_in;
    fval[F_Z] = (res == '0);
    fval[F_N] = n_b;
    fval[F_V] = v_b;
    fval[F_S] = n_b ^ v_b;
    fupd      = '0;
    if (is_arith || is_logic) begin
      fupd[F_Z] = 1'b1;
      fupd[F_N] = 1'b1;
      fupd[F_V] = 1'b1;
      fupd[F_S] = 1'b1;
    end
    if (is_arith) begin
      fupd[F_C] = 1'b1;
      fupd[F_H] = 1'b1;
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int W = 8
) (
  input  logic [3:0]                 op_sel,
  input  logic [W-1:0]               opd_a,
  input  logic [W-1:0]               opd_b,
  input  logic                       carry_in,
  output logic [W-1:0]               res,
  output logic                       res_wr,
  output logic [alu8_pkg::NFLAG-1:0] flag_val,
  output logic [alu8_pkg::NFLAG-1:0] flag_upd
);
  import alu8_pkg::*;

  logic      is_arith, is_logic, is_sub, cin_eff;
  bw_sel_e   bw_sel;
  logic [W-1:0] sum_y, bw_y;
  logic      c_a, h_a, v_a;

  // operation decode
  always_comb begin
    is_arith = 1'b0;
    is_logic = 1'b0;
    is_sub   = 1'b0;
    cin_eff  = 1'b0;
    res_wr   = 1'b0;
    bw_sel   = BW_AND;
    case (op_sel)
      OP_ADD:  begin is_arith = 1'b1; res_wr = 1'b1; end
      OP_ADC:  begin is_arith = 1'b1; res_wr = 1'b1; cin_eff = carry_in; end
      OP_SUB:  begin is_arith = 1'b1; res_wr = 1'b1; is_sub = 1'b1; cin_eff = 1'b1; end
      OP_SBC:  begin is_arith = 1'b1; res_wr = 1'b1; is_sub = 1'b1; cin_eff = ~carry_in; end
      OP_CMP:  begin is_arith = 1'b1; is_sub = 1'b1; cin_eff = 1'b1; end
      OP_CMPC: begin is_arith = 1'b1; is_sub = 1'b1; cin_eff = ~carry_in; end
      OP_AND:  begin is_logic = 1'b1; res_wr = 1'b1; bw_sel = BW_AND; end
      OP_OR:   begin is_logic = 1'b1; res_wr = 1'b1; bw_sel = BW_OR; end
      OP_XOR:  begin is_logic = 1'b1; res_wr = 1'b1; bw_sel = BW_XOR; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a(opd_a), .b(opd_b), .sub(is_sub), .cin(cin_eff),
    .sum(sum_y), .c_out(c_a), .h_out(h_a), .v_out(v_a)
  );

  alu8_bitwise #(.W(W)) u_bitwise (
    .a(opd_a), .b(opd_b), .sel(bw_sel), .y(bw_y)
  );

  always_comb begin
    if (is_arith)      res = sum_y;
    else if (is_logic) res = bw_y;
    else               res = '0;
  end

  alu8_flagpack #(.W(W)) u_flags (
    .res(res), .is_arith(is_arith), .is_logic(is_logic),
    .c_in(c_a), .h_in(h_a), .v_in(v_a),
    .fval(flag_val), .fupd(flag_upd)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int W = 8
) (
  input logic [3:0]                 op_sel,
  input logic [W-1:0]               opd_a,
  input logic [W-1:0]               opd_b,
  input logic                       carry_in,
  input logic [W-1:0]               res,
  input logic                       res_wr,
  input logic [alu8_pkg::NFLAG-1:0] flag_val,
  input logic [alu8_pkg::NFLAG-1:0] flag_upd
);
  import alu8_pkg::*;
  logic [W:0] add_ref;
  assign add_ref = {1'b0, opd_a} + {1'b0, opd_b};

  always_comb begin
    // R1: plain add matches a wide sum, carry in bit W
    if (op_sel == OP_ADD)
      a_r1_add_sum: assert ({flag_val[F_C], res} == add_ref);
    // R5: compares never request a write
    if (op_sel == OP_CMP || op_sel == OP_CMPC)
      a_r5_cmp_nowrite: assert (!res_wr);
    // R8: sign flag relation
    if (flag_upd[F_S])
      a_r8_sign_rule: assert (flag_val[F_S] == (flag_val[F_N] ^ flag_val[F_V]));
    // R8: zero flag follows the result byte
    if (flag_upd[F_Z])
      a_r8_zero_rule: assert (flag_val[F_Z] == (res == '0));
    // R9/R10: logic ops clear V and keep C and H
    if (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR)
      a_r9_logic_flags: assert (!flag_val[F_V] && !flag_upd[F_C] && !flag_upd[F_H]);
    // R11: unused codes touch nothing
    if (op_sel > 4'd8)
      a_r11_unused_quiet: assert (flag_upd == '0 && !res_wr);
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_sel;
  logic [7:0] opd_a, opd_b;
  logic       carry_in;
  logic [7:0] res;
  logic       res_wr;
  logic [5:0] flag_val, flag_upd;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu8_core u0 (
    .op_sel(op_sel), .opd_a(opd_a), .opd_b(opd_b), .carry_in(carry_in),
    .res(res), .res_wr(res_wr), .flag_val(flag_val), .flag_upd(flag_upd)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // apply one operation and check every output against integer math
  task automatic run_op(input int op, input int a, input int b, input bit ci);
    int full, er, sv, bw;
    bit ec, eh, ev, arith, logic_op, ewr;
    int eflags, emask;
    op_sel = op[3:0]; opd_a = a[7:0]; opd_b = b[7:0]; carry_in = ci;
    #2;
    arith = (op <= 5); logic_op = (op >= 6 && op <= 8);
    er = 0; ec = 0; eh = 0; ev = 0;
    if (op <= 1) begin
      bw = (op == 1) ? int'(ci) : 0;
      full = a + b + bw; er = full & 255; ec = full > 255;
      eh = ((a & 15) + (b & 15) + bw) > 15;
      sv = sgn(a) + sgn(b) + bw; ev = (sv > 127) || (sv < -128);
    end else if (op <= 5) begin
      bw = (op == 3 || op == 5) ? int'(ci) : 0;
      full = a - b - bw; er = full & 255; ec = full < 0;
      eh = ((a & 15) - (b & 15) - bw) < 0;
      sv = sgn(a) - sgn(b) - bw; ev = (sv > 127) || (sv < -128);
    end else if (op == 6) er = a & b;
    else if (op == 7) er = a | b;
    else if (op == 8) er = a ^ b;
    ewr = (op <= 3) || logic_op;
    eflags = 0; emask = 0;
    if (arith || logic_op) begin
      eflags = int'(ec) | (int'(er == 0) << 1) | (((er >> 7) & 1) << 2)
             | (int'(ev) << 3) | ((((er >> 7) & 1) ^ int'(ev)) << 4) | (int'(eh) << 5);
      emask = arith ? 6'h3F : 6'h1E;
    end
    if (arith || logic_op) cmp($sformatf("R1-R4/R9 res op=%0d a=%0h b=%0h", op, a, b), res, er);
    cmp($sformatf("R5 wr op=%0d", op), res_wr, ewr);
    if (arith) begin
      cmp($sformatf("R6 C op=%0d a=%0h b=%0h", op, a, b), flag_val[0], ec);
      cmp($sformatf("R6 H op=%0d a=%0h b=%0h", op, a, b), flag_val[5], eh);
      cmp($sformatf("R7 V op=%0d a=%0h b=%0h", op, a, b), flag_val[3], ev);
    end
    if (arith || logic_op)
      cmp($sformatf("R8 N/Z/S op=%0d a=%0h b=%0h", op, a, b), flag_val[4:1], (eflags >> 1) & 15);
    cmp($sformatf("R10 mask op=%0d", op), flag_upd, emask);
    #3;
  endtask

  task automatic t_idle();  // R11 and power-up state of outputs
    run_op(12, 8'h55, 8'hAA, 1'b1);
    cmp("R11 mask idle", flag_upd, 0);
    cmp("R11 wr idle", res_wr, 0);
    run_op(9, 0, 0, 0);
    run_op(15, 8'hFF, 8'hFF, 1'b1);
  endtask

  task automatic t_add();  // R1: carry_in ignored
    run_op(0, 8'h7F, 8'h01, 1'b1);
    cmp("R1 cin ignored", res, 8'h80);
    run_op(0, 8'hFF, 8'h01, 1'b0);
    run_op(0, 8'h0F, 8'h01, 1'b0);
    run_op(0, 8'h80, 8'h80, 1'b1);
    run_op(0, 8'h12, 8'h34, 1'b0);
  endtask

  task automatic t_adc();  // R2
    run_op(1, 8'hFF, 8'h00, 1'b1);
    run_op(1, 8'h7F, 8'h00, 1'b1);
    run_op(1, 8'h0E, 8'h01, 1'b1);
    run_op(1, 8'h40, 8'h3F, 1'b0);
  endtask

  task automatic t_sub();  // R3, R6 borrow, R7
    run_op(2, 8'h00, 8'h01, 1'b0);
    run_op(2, 8'h80, 8'h01, 1'b1);
    run_op(2, 8'h10, 8'h01, 1'b0);
    run_op(2, 8'h33, 8'h33, 1'b0);
    run_op(2, 8'h7F, 8'hFF, 1'b0);
  endtask

  task automatic t_sbc();  // R4
    run_op(3, 8'h05, 8'h05, 1'b1);
    run_op(3, 8'h05, 8'h04, 1'b1);
    run_op(3, 8'h80, 8'h00, 1'b1);
    run_op(3, 8'h20, 8'h0F, 1'b0);
  endtask

  task automatic t_cmp();  // R5 compares
    run_op(4, 8'h10, 8'h20, 1'b0);
    run_op(4, 8'h44, 8'h44, 1'b1);
    run_op(5, 8'h00, 8'h00, 1'b1);
    run_op(5, 8'h81, 8'h01, 1'b0);
  endtask

  task automatic t_logic();  // R9, R10
    run_op(6, 8'hF0, 8'h0F, 1'b1);
    run_op(6, 8'hC3, 8'h81, 1'b0);
    run_op(7, 8'h80, 8'h01, 1'b1);
    run_op(7, 8'h00, 8'h00, 1'b0);
    run_op(8, 8'hAA, 8'hAA, 1'b1);
    run_op(8, 8'hA5, 8'h5A, 1'b0);
  endtask

  task automatic t_sweep();  // R1-style coverage over a stride of operands
    for (int i = 0; i < 256; i += 37)
      for (int j = 0; j < 256; j += 53)
        for (int o = 0; o < 9; o++) run_op(o, i, j, 1'((i + j + o) & 1));
  endtask

  initial begin
    op_sel = 4'd15; opd_a = '0; opd_b = '0; carry_in = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_idle();
    t_add();
    t_adc();
    t_sub();
    t_sbc();
    t_cmp();
    t_logic();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule